// File: doc/BRIEF.md
# Reloading Interval Timer

This block is a down counter that advances on an interval clock enable supplied by a clock generator outside the block. When the count is zero, the next enable does not decrement. It loads the programmed reload value instead and emits a one-cycle interrupt pulse. The period is therefore the reload value plus one ticks. With a 1 MHz enable, one tick gives 1 µs of resolution.

Software programs the 12-bit reload value over an 8-bit bus in two byte writes. The low byte waits in a holding register. The high-byte write then commits all twelve bits in a single cycle. A reload that happens between the two writes therefore always uses a complete value. The committed value can be read back one byte at a time while the counter runs.

Top module: `irt_timer`

## Requirements
- R1: After a synchronous reset the count, the committed reload value, the read data and the interrupt are all zero.
- R2: On a system clock edge with the tick enable high and a nonzero count, the count drops by exactly one. With the tick enable low, the count holds.
- R3: On a tick edge where the count is zero, the count takes the committed reload value. The period from one reload to the next is reload value plus one ticks.
- R4: The interrupt output is high for exactly the one system clock cycle after each reload edge, and it is low at all other times.
- R5: A write with byte select 0 (low byte) only fills the holding register. It changes neither the committed reload value, its readback, nor the value that the next reload uses.
- R6: A write with byte select 1 (high byte) commits {data[3:0], held low byte} as the 12-bit reload value in one cycle. Data bits 7:4 are ignored.
- R7: When a commit and a reload fall on the same edge, the reload uses the previously committed value, and the new value takes effect from the next reload.
- R8: The read data is registered with one cycle of latency. Select 0 returns reload bits 7:0. Select 1 returns reload bits 11:8 zero-extended to 8 bits.
- R9: With a reload value of zero, which is the state after reset, every tick reloads and raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Interval clock enable, one tick per high cycle |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 1 | Write byte select: 0 low, 1 high (commit) |
| wr_data | input | 8 | Write data byte |
| rd_sel | input | 1 | Read byte select: 0 low, 1 high |
| rd_data | output | 8 | Registered read data of the committed reload value |
| count | output | 12 | Current counter value |
| irq | output | 1 | One-cycle reload interrupt pulse |

## Verification
Two events can land on the same clock edge: the commit of a new reload value, and the count reaching zero under a tick. The bench drives the high-byte write and the tick enable in the same cycle while the count is zero. It passes only if the count takes the old committed value and the readback then shows the new one. In the same way, a low-byte write issued on a reload edge must leave both the loaded count and the readback unchanged.

// File: rtl/irt_pkg.sv
package irt_pkg;
  // byte lane select for the split reload access
  localparam logic SEL_LO = 1'b0;
  localparam logic SEL_HI = 1'b1;
endpackage

// File: rtl/irt_reload_regs.sv
module irt_reload_regs #(
  parameter int CNT_W = 12,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [BUS_W-1:0] rd_data,
  output logic [CNT_W-1:0] reload_val
);
  import irt_pkg::*;
  localparam int HI_W  = CNT_W - BUS_W;
  localparam int PAD_W = BUS_W - HI_W;

  logic [BUS_W-1:0] hold_q;

  // low byte parks in hold_q; high byte commits the whole word at once
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= '0;
      reload_val <= '0;
      rd_data    <= '0;
    end else begin
      if (wr_en && wr_sel == SEL_LO) hold_q <= wr_data;
      if (wr_en && wr_sel == SEL_HI) reload_val <= {wr_data[HI_W-1:0], hold_q};
      if (rd_sel == SEL_HI) rd_data <= {{PAD_W{1'b0}}, reload_val[CNT_W-1:BUS_W]};
      else                  rd_data <= reload_val[BUS_W-1:0];
    end
  end

  assert_lo_no_commit_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_LO) |=> $stable(reload_val));
  assert_commit_word_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_HI) |=> reload_val == {$past(wr_data[HI_W-1:0]), $past(hold_q)});
endmodule

// File: rtl/irt_down_counter.sv
module irt_down_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic at_zero;
  assign at_zero = (count == '0);

  // a tick at zero is consumed by the reload; irq registered with it
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= tick_en && at_zero;
      if (tick_en) begin
        if (at_zero) count <= reload_val;
        else         count <= count - ONE;
      end
    end
  end

  assert_dec_one_R2: assert property (@(posedge clk) disable iff (rst)
    (tick_en && count != '0) |=> count == $past(count) - ONE);
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(count));
  assert_reload_old_R3: assert property (@(posedge clk) disable iff (rst)
    (tick_en && count == '0) |=> count == $past(reload_val));
  assert_irq_on_reload_R4: assert property (@(posedge clk) disable iff (rst)
    (tick_en && count == '0) |=> irq);
  assert_irq_only_reload_R4: assert property (@(posedge clk) disable iff (rst)
    !(tick_en && count == '0) |=> !irq);
endmodule

// File: rtl/irt_timer.sv
module irt_timer #(
  parameter int CNT_W = 12,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [BUS_W-1:0] rd_data,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  logic [CNT_W-1:0] reload_val;

  irt_reload_regs #(.CNT_W(CNT_W), .BUS_W(BUS_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .reload_val(reload_val)
  );

  irt_down_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .reload_val(reload_val),
    .count(count), .irq(irq)
  );

  // reset state check, R1
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (count == '0 && reload_val == '0 && !irq));
endmodule

// File: tb/irt_timer_tb.sv
`timescale 1ns/1ps
module irt_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic [11:0] count;
  logic       irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irt_timer dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .count(count), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // one cycle with chosen inputs, then sample
  task automatic cycle(input bit t, input bit w, input bit s, input logic [7:0] d);
    @(negedge clk);
    tick_en = t; wr_en = w; wr_sel = s; wr_data = d;
    @(negedge clk);
    tick_en = 0; wr_en = 0;
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk);
    tick_en = 1;
    repeat (n) @(negedge clk);
    tick_en = 0;
  endtask

  task automatic read_byte(input bit s, output int v);
    @(negedge clk);
    rd_sel = s;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic t_reset();
    int v;
    check("R1 count", count, 0);
    check("R1 irq", irq, 0);
    read_byte(0, v); check("R1 read lo", v, 0);
    read_byte(1, v); check("R1 read hi", v, 0);
  endtask

  task automatic t_zero_reload();
    cycle(1, 0, 0, 0);
    check("R9 count stays zero", count, 0);
    check("R9 irq on tick", irq, 1);
    cycle(0, 0, 0, 0);
    check("R4 irq single cycle", irq, 0);
    cycle(1, 0, 0, 0);
    check("R9 irq again", irq, 1);
  endtask

  task automatic t_program_and_period();
    int v;
    cycle(0, 1, 0, 8'h05);
    read_byte(0, v); check("R5 low write not visible", v, 0);
    cycle(1, 0, 0, 0);
    check("R5 reload uses committed zero", count, 0);
    cycle(0, 1, 1, 8'hF0);
    read_byte(0, v); check("R8 read lo", v, 8'h05);
    read_byte(1, v); check("R6 upper bits ignored", v, 0);
    cycle(1, 0, 0, 0);
    check("R3 load 5", count, 5);
    check("R4 irq at load", irq, 1);
    cycle(0, 0, 0, 0);
    cycle(0, 0, 0, 0);
    check("R2 idle holds", count, 5);
    for (int i = 4; i >= 0; i--) begin
      cycle(1, 0, 0, 0);
      check("R2 decrement", count, i);
      check("R4 no irq while counting", irq, 0);
    end
    cycle(1, 0, 0, 0);
    check("R3 period reload+1", count, 5);
    check("R3 irq at period end", irq, 1);
    run_ticks(5);
    check("R2 back to zero", count, 0);
  endtask

  task automatic t_coincide();
    int v;
    cycle(0, 1, 0, 8'h34);
    cycle(1, 1, 1, 8'hA2);
    check("R7 reload uses old value", count, 5);
    check("R7 irq", irq, 1);
    read_byte(1, v); check("R8 read hi zero-extended", v, 8'h02);
    read_byte(0, v); check("R8 read lo", v, 8'h34);
    run_ticks(5);
    check("R7 zero again", count, 0);
    cycle(1, 1, 0, 8'h77);
    check("R7 new value takes effect", count, 12'h234);
    read_byte(0, v); check("R5 low write at reload not visible", v, 8'h34);
    run_ticks(12'h234);
    check("R2 long run to zero", count, 0);
    check("R4 no irq at zero", irq, 0);
    cycle(1, 0, 0, 0);
    check("R3 long period", count, 12'h234);
    check("R4 irq long period", irq, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_zero_reload();
    t_program_and_period();
    t_coincide();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule